// File: doc/BRIEF.md
# Edge-Triggered Interrupt Status Unit

This unit turns two peripheral event signals into one host interrupt line. The first source is the level of a pen-contact comparator. The second is a one-cycle pulse raised when an analog-to-digital conversion finishes. Each source passes through a synchronizer and an edge detector. Two enable registers choose, for each source, whether a rising edge, a falling edge, or both latch its bit in a sticky status register. The interrupt output is a registered OR of every status bit, active high, so the host sees a rising edge when the first event is pending.

Software reaches the unit over a plain 16-bit register bus with a combinational read port. Status is read and cleared at the same address. A write there loads a clear mask. Any mask bit that is 1 holds its status bit at zero, and a following write of zero releases the mask. A small two-state sequencer tracks this. In state `CLR_OPEN` no mask applies. A nonzero write moves it to `CLR_HOLD`, which applies the written mask. Another nonzero write stays in `CLR_HOLD` with the new mask. A zero write returns it to `CLR_OPEN`. Reset puts the sequencer in `CLR_OPEN`.

Top module: `edge_irq_unit`

## Requirements
- R1: After reset, both enable registers and the status register read 0, `irq` is 0, and the clear sequencer is in `CLR_OPEN`, so the next enabled edge latches normally.
- R2: Address 0x5E holds the rising-edge enables and 0x60 holds the falling-edge enables. Only bit 11 (conversion-done source) and bit 12 (pen source) are stored. All other bits read 0.
- R3: With its rising enable set, a 0-to-1 change on a source sets its status bit. The bit can be read no later than the third rising clock edge after the edge that first samples the change.
- R4: With its falling enable set, a 1-to-0 change on a source sets its status bit, with the same timing as R3.
- R5: An edge whose enable bit is 0 leaves the status register unchanged.
- R6: A status bit stays set after its source returns to its idle level, until it is cleared.
- R7: A nonzero write to address 0x62 clears the status bits that are 1 in the written value. Bits that are 0 in the written value keep their state.
- R8: While a nonzero clear mask is held, events on the masked bits are discarded. A write of 0 to 0x62 releases the mask, and new edges latch again.
- R9: `irq` is the OR of all status bits, delayed by one register.
- R10: Writing 0xFFFF and then 0 to address 0x62 clears every pending bit and drops `irq`.
- R11: A read from any address outside 0x5E, 0x60 and 0x62 returns 0, and a write to such an address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 7 | Register address for both read and write |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| pen_level | input | 1 | Pen-contact comparator level, asynchronous |
| adc_done | input | 1 | Conversion-complete pulse, at least one clock wide |
| irq | output | 1 | Active-high interrupt request |

## Verification
A source change sampled on clock edge k appears in the second synchronizer stage after edge k+1. The status bit sets at edge k+2, and `irq` follows at edge k+3. A clear or enable write at edge e takes effect on status at edge e+1. Each vector drives its inputs on a falling edge and removes the write strobe one cycle later. The bench then waits four more falling edges before it reads status and `irq`, which is past the latest edge at which any result is due. Reset values are read on the first falling edge after reset is released.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
    // register addresses that software decodes
    localparam logic [6:0] ADDR_RISE_EN = 7'h5E;
    localparam logic [6:0] ADDR_FALL_EN = 7'h60;
    localparam logic [6:0] ADDR_STATUS  = 7'h62;

    // status and enable bit positions
    localparam int BIT_ADC = 11;
    localparam int BIT_PEN = 12;

    // source vector ordering for the edge detector
    localparam int SRC_ADC = 0;
    localparam int SRC_PEN = 1;
    localparam int NUM_SRC = 2;

    typedef enum logic {
        CLR_OPEN = 1'b0,
        CLR_HOLD = 1'b1
    } clr_state_e;
endpackage

// File: rtl/eirq_edge.sv
module eirq_edge #(
    parameter int NSRC   = 2,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src,
    output logic [NSRC-1:0] rise,
    output logic [NSRC-1:0] fall
);
    // STAGES synchronizer flops plus one history flop per source
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        logic [STAGES:0] shift_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) shift_q <= '0;
            else        shift_q <= {shift_q[STAGES-1:0], src[g]};
        end

        assign rise[g] =  shift_q[STAGES-1] & ~shift_q[STAGES];
        assign fall[g] = ~shift_q[STAGES-1] &  shift_q[STAGES];
    end
endmodule

// File: rtl/eirq_clr_seq.sv
module eirq_clr_seq
    import eirq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_status,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] clr_mask
);
    clr_state_e        state_q, state_d;
    logic [DATA_W-1:0] mask_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CLR_OPEN: if (wr_status && (wdata != '0)) state_d = CLR_HOLD;
            CLR_HOLD: if (wr_status && (wdata == '0)) state_d = CLR_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CLR_OPEN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         mask_q <= '0;
        else if (wr_status) mask_q <= wdata;
    end

    always_comb begin
        unique case (state_q)
            CLR_OPEN: clr_mask = '0;
            CLR_HOLD: clr_mask = mask_q;
        endcase
    end

    // R8
    hold_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CLR_HOLD) |-> (mask_q != '0));
endmodule

// File: rtl/edge_irq_unit.sv
module edge_irq_unit
    import eirq_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              pen_level,
    input  logic              adc_done,
    output logic              irq
);
    localparam logic [DATA_W-1:0] IMPL_MASK =
        (DATA_W'(1) << BIT_ADC) | (DATA_W'(1) << BIT_PEN);

    logic [NUM_SRC-1:0] src, rise, fall;
    logic [DATA_W-1:0]  rise_en_q, fall_en_q, status_q, set_vec, clr_mask;
    logic               irq_q;
    logic               sel_rise, sel_fall, sel_stat;

    assign src[SRC_ADC] = adc_done;
    assign src[SRC_PEN] = pen_level;

    assign sel_rise = (bus_addr == ADDR_W'(ADDR_RISE_EN));
    assign sel_fall = (bus_addr == ADDR_W'(ADDR_FALL_EN));
    assign sel_stat = (bus_addr == ADDR_W'(ADDR_STATUS));

    eirq_edge #(.NSRC(NUM_SRC), .STAGES(SYNC_STAGES)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .src  (src),
        .rise (rise),
        .fall (fall)
    );

    eirq_clr_seq #(.DATA_W(DATA_W)) u_clr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_status(bus_we && sel_stat),
        .wdata    (bus_wdata),
        .clr_mask (clr_mask)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_en_q <= '0;
            fall_en_q <= '0;
        end else if (bus_we) begin
            if (sel_rise) rise_en_q <= bus_wdata & IMPL_MASK;
            if (sel_fall) fall_en_q <= bus_wdata & IMPL_MASK;
        end
    end

    always_comb begin
        set_vec          = '0;
        set_vec[BIT_ADC] = (rise[SRC_ADC] & rise_en_q[BIT_ADC]) |
                           (fall[SRC_ADC] & fall_en_q[BIT_ADC]);
        set_vec[BIT_PEN] = (rise[SRC_PEN] & rise_en_q[BIT_PEN]) |
                           (fall[SRC_PEN] & fall_en_q[BIT_PEN]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            irq_q    <= 1'b0;
        end else begin
            status_q <= (status_q | set_vec) & ~clr_mask & IMPL_MASK;
            irq_q    <= |status_q;
        end
    end

    assign irq = irq_q;

    always_comb begin
        if      (sel_rise) bus_rdata = rise_en_q;
        else if (sel_fall) bus_rdata = fall_en_q;
        else if (sel_stat) bus_rdata = status_q;
        else               bus_rdata = '0;
    end

    // R8
    held_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask != '0) |=> ((status_q & $past(clr_mask)) == '0));

    // R9
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (irq_q == (|$past(status_q))));

    // R3 R4 R5
    adc_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_q[BIT_ADC]) |->
            $past((rise[SRC_ADC] & rise_en_q[BIT_ADC]) | (fall[SRC_ADC] & fall_en_q[BIT_ADC])));

    // R3 R4 R5
    pen_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_q[BIT_PEN]) |->
            $past((rise[SRC_PEN] & rise_en_q[BIT_PEN]) | (fall[SRC_PEN] & fall_en_q[BIT_PEN])));
endmodule

// File: tb/sim_edge_irq_unit.sv
module sim_edge_irq_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        pen_level = 1'b0;
    logic        adc_done = 1'b0;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;  // 250 MHz

    edge_irq_unit u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .pen_level(pen_level),
        .adc_done (adc_done),
        .irq      (irq)
    );

    typedef struct packed {
        logic [7:0]  req;
        logic        we;
        logic [6:0]  waddr;
        logic [15:0] wdata;
        logic        pen;
        logic        adc;
        logic [6:0]  raddr;
        logic [15:0] exp;
        logic        exp_irq;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{8'd2,  1'b1, 7'h5E, 16'h1800, 1'b0, 1'b0, 7'h5E, 16'h1800, 1'b0}, // R2 rise enables
        '{8'd2,  1'b1, 7'h60, 16'h1000, 1'b0, 1'b0, 7'h60, 16'h1000, 1'b0}, // R2 fall enable
        '{8'd3,  1'b0, 7'h00, 16'h0000, 1'b0, 1'b1, 7'h62, 16'h0800, 1'b1}, // R3 adc pulse
        '{8'd7,  1'b1, 7'h62, 16'h0800, 1'b0, 1'b0, 7'h62, 16'h0000, 1'b0}, // R7 clear adc
        '{8'd8,  1'b0, 7'h00, 16'h0000, 1'b0, 1'b1, 7'h62, 16'h0000, 1'b0}, // R8 masked event lost
        '{8'd8,  1'b1, 7'h62, 16'h0000, 1'b0, 1'b0, 7'h62, 16'h0000, 1'b0}, // R8 release
        '{8'd3,  1'b0, 7'h00, 16'h0000, 1'b1, 1'b0, 7'h62, 16'h1000, 1'b1}, // R3 pen rise
        '{8'd10, 1'b1, 7'h62, 16'hFFFF, 1'b1, 1'b0, 7'h62, 16'h0000, 1'b0}, // R10 clear all
        '{8'd4,  1'b1, 7'h62, 16'h0000, 1'b0, 1'b0, 7'h62, 16'h1000, 1'b1}, // R4 pen fall
        '{8'd6,  1'b0, 7'h00, 16'h0000, 1'b0, 1'b1, 7'h62, 16'h1800, 1'b1}, // R6 sticky, both
        '{8'd7,  1'b1, 7'h62, 16'h1000, 1'b0, 1'b0, 7'h62, 16'h0800, 1'b1}, // R7 partial clear
        '{8'd9,  1'b1, 7'h62, 16'h0000, 1'b0, 1'b0, 7'h62, 16'h0800, 1'b1}, // R9 irq held
        '{8'd10, 1'b1, 7'h62, 16'hFFFF, 1'b0, 1'b0, 7'h62, 16'h0000, 1'b0}, // R10 mask all
        '{8'd10, 1'b1, 7'h62, 16'h0000, 1'b0, 1'b0, 7'h62, 16'h0000, 1'b0}, // R10 release
        '{8'd5,  1'b1, 7'h5E, 16'h0000, 1'b1, 1'b0, 7'h62, 16'h0000, 1'b0}, // R5 rise disabled
        '{8'd5,  1'b1, 7'h60, 16'h0000, 1'b0, 1'b0, 7'h62, 16'h0000, 1'b0}, // R5 fall disabled
        '{8'd11, 1'b1, 7'h10, 16'hFFFF, 1'b0, 1'b0, 7'h10, 16'h0000, 1'b0}, // R11 unmapped
        '{8'd2,  1'b1, 7'h5E, 16'hFFFF, 1'b0, 1'b0, 7'h5E, 16'h1800, 1'b0}  // R2 unused bits
    };

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%04h expected 0x%04h", req, got, exp);
        end
    endtask

    task automatic read_chk(input string req, input logic [6:0] a, input logic [15:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic run_vec(input vec_t v);
        @(negedge clk);
        bus_we = v.we; bus_addr = v.waddr; bus_wdata = v.wdata;
        pen_level = v.pen; adc_done = v.adc;
        @(negedge clk);
        bus_we = 1'b0; adc_done = 1'b0; bus_addr = v.raddr;
        repeat (4) @(negedge clk);
        check($sformatf("R%0d data", v.req), bus_rdata, v.exp);
        check($sformatf("R%0d irq", v.req), {15'd0, irq}, {15'd0, v.exp_irq});
    endtask

    task automatic do_write(input logic [6:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        read_chk("R1 rise_en", 7'h5E, 16'h0000);
        read_chk("R1 fall_en", 7'h60, 16'h0000);
        read_chk("R1 status",  7'h62, 16'h0000);
        check("R1 irq", {15'd0, irq}, 16'h0000);

        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R3 adc again, then reset mid-run (R1)
        @(negedge clk); adc_done = 1'b1;
        @(negedge clk); adc_done = 1'b0;
        repeat (4) @(negedge clk);
        read_chk("R3 status before reset", 7'h62, 16'h0800);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        read_chk("R1 rise_en after reset", 7'h5E, 16'h0000);
        read_chk("R1 status after reset",  7'h62, 16'h0000);
        check("R1 irq after reset", {15'd0, irq}, 16'h0000);

        // R1 clear sequencer open after reset: event latches at once
        do_write(7'h5E, 16'h0800);
        @(negedge clk); adc_done = 1'b1;
        @(negedge clk); adc_done = 1'b0;
        repeat (4) @(negedge clk);
        read_chk("R1 latch after reset", 7'h62, 16'h0800);
        check("R9 irq after latch", {15'd0, irq}, 16'h0001);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule